// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Unit

This block advances the eight path metrics of a trellis decoder by one step on every clock cycle in which its enable is high. For each state it builds four candidate sums. Each sum adds one previous state metric to one branch metric, and both are chosen through fixed index tables that are set at elaboration. The smallest of the four candidates becomes the state's new metric. A 2-bit decision code records which candidate won, for use by a later traceback stage.

Two build variants are available. The direct variant resolves the four-way minimum in one cycle. It runs all six pairwise comparisons at once and decodes their sign bits. The split variant registers two half-minima and the sign of the comparison between them, then applies the final two-way choice in the next cycle. In the split variant the recursion reads through that choice, so the sequence of metrics does not change. The registered metric outputs lag the decisions by one cycle.

Top module: `acs_radix4`

## Requirements
- R1: An active-high synchronous reset sets state 0 to metric 0, every other state to 8191 (the largest 14-bit signed value), and every decision code to 0. This holds in both variants.
- R2: With enable high, state s takes the minimum over c = 0..3 of candidate c. Candidate c is metric[(4s+c) mod 8] + branch[(s+3c) mod 8]. This is the default index table. The metrics and the eight branch inputs are 14-bit signed values packed with index i at bits [14i+13:14i].
- R3: Each candidate sum is formed at 15 bits and clamped to the range -8192..8191 before any comparison. A sum outside that range becomes the nearer limit and never wraps.
- R4: The decision code of state s, at bits [2s+1:2s] of the decision output, is the index 0..3 of the winning candidate. When candidates are equal, the lowest index wins.
- R5: A metric written at one clock edge is a candidate source at the very next edge. This includes state 0, whose candidate 0 is its own metric.
- R6: With enable low, the metric and decision outputs keep their values whatever the branch inputs are.
- R7: In the split variant the decisions appear in the same cycle as in the direct variant. The metric outputs show the value the direct variant showed one enabled cycle earlier: they load only at an edge that follows an edge with enable high.
- R8: The four-way minimum marks exactly one winner, and its value is no larger than any of the four candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the recursion by one trellis step |
| bm_i | input | 112 | Eight 14-bit signed branch metrics, branch i at bits [14i+13:14i] |
| metric_o | output | 112 | Eight 14-bit signed state metrics, state i at bits [14i+13:14i] |
| dec_o | output | 16 | Eight 2-bit decision codes, state i at bits [2i+1:2i] |

## Verification
The bench builds the unit twice from the same stimulus: once with the mode parameter set to the direct variant and once with it set to the split variant. Both use the default index tables, in which state 0 feeds itself and every state draws on four distinct predecessors. Driving the two side by side checks the split variant's one-cycle lag of the metric outputs against the same model sequence, while its decisions must match in the same cycle. The default tables also give equal-candidate ties straight after reset. Branch metrics pinned at the signed limits make the clamp decide the result.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;
    localparam int NUM_ST   = 8;
    localparam int NUM_CAND = 4;
    localparam int MW       = 14;
    localparam int SIDX_W   = $clog2(NUM_ST);
    localparam int DEC_W    = $clog2(NUM_CAND);
    localparam int TAB_W    = NUM_ST * NUM_CAND * SIDX_W;
    localparam int VEC_W    = NUM_ST * MW;

    typedef logic signed [MW-1:0] metric_t;
    typedef logic [DEC_W-1:0]     dec_t;

    localparam metric_t MET_MAX = metric_t'({1'b0, {(MW-1){1'b1}}});
    localparam metric_t MET_MIN = metric_t'({1'b1, {(MW-1){1'b0}}});

    typedef enum logic {MODE_DIRECT, MODE_SPLIT} acs_mode_e;

    // one half of the split minimum: value and which of its pair won
    typedef struct packed {
        metric_t val;
        logic    pick;
    } half_t;

    // 15-bit sum, clamped back into the 14-bit signed range
    function automatic metric_t sat_add(metric_t a, metric_t b);
        logic signed [MW:0] s;
        s = {a[MW-1], a} + {b[MW-1], b};
        if (s[MW] != s[MW-1])
            return s[MW] ? MET_MIN : MET_MAX;
        return s[MW-1:0];
    endfunction

    // a < b, decided from the sign of a widened subtraction
    function automatic logic less_than(metric_t a, metric_t b);
        logic signed [MW:0] d;
        d = {a[MW-1], a} - {b[MW-1], b};
        return d[MW];
    endfunction

    function automatic logic [TAB_W-1:0] src_tab_default();
        logic [TAB_W-1:0] t;
        t = '0;
        for (int s = 0; s < NUM_ST; s++)
            for (int c = 0; c < NUM_CAND; c++)
                t[(s*NUM_CAND+c)*SIDX_W +: SIDX_W] = SIDX_W'((NUM_CAND*s + c) % NUM_ST);
        return t;
    endfunction

    function automatic logic [TAB_W-1:0] bm_tab_default();
        logic [TAB_W-1:0] t;
        t = '0;
        for (int s = 0; s < NUM_ST; s++)
            for (int c = 0; c < NUM_CAND; c++)
                t[(s*NUM_CAND+c)*SIDX_W +: SIDX_W] = SIDX_W'((s + 3*c) % NUM_ST);
        return t;
    endfunction

    function automatic logic [VEC_W-1:0] reset_metrics();
        logic [VEC_W-1:0] v;
        for (int s = 0; s < NUM_ST; s++)
            v[s*MW +: MW] = (s == 0) ? metric_t'(0) : MET_MAX;
        return v;
    endfunction
endpackage

// File: rtl/acs_cand_gen.sv
`timescale 1ns/1ps
module acs_cand_gen
    import acs_pkg::*;
#(
    parameter int               STATE   = 0,
    parameter logic [TAB_W-1:0] SRC_TAB = src_tab_default(),
    parameter logic [TAB_W-1:0] BM_TAB  = bm_tab_default()
) (
    input  logic [VEC_W-1:0]         met_i,
    input  logic [VEC_W-1:0]         bm_i,
    output logic [NUM_CAND*MW-1:0]   cand_o
);
    for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
        localparam int SRC = int'(SRC_TAB[(STATE*NUM_CAND+c)*SIDX_W +: SIDX_W]);
        localparam int BMI = int'(BM_TAB[(STATE*NUM_CAND+c)*SIDX_W +: SIDX_W]);
        assign cand_o[c*MW +: MW] = sat_add(metric_t'(met_i[SRC*MW +: MW]),
                                            metric_t'(bm_i[BMI*MW +: MW]));
    end
endmodule

// File: rtl/acs_min4.sv
`timescale 1ns/1ps
module acs_min4
    import acs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CAND*MW-1:0] cand_i,
    output metric_t                min_o,
    output dec_t                   win_o
);
    metric_t                              c [NUM_CAND];
    logic [NUM_CAND-1:0][NUM_CAND-1:0]    le;
    logic [NUM_CAND-1:0]                  w;

    always_comb begin
        for (int i = 0; i < NUM_CAND; i++)
            c[i] = metric_t'(cand_i[i*MW +: MW]);
        le = '0;
        // six subtractions in parallel: le[i][j] means c[i] <= c[j], i < j
        for (int i = 0; i < NUM_CAND; i++)
            for (int j = i + 1; j < NUM_CAND; j++)
                le[i][j] = !less_than(c[j], c[i]);
        // candidate i wins if strictly below lower indices and not above higher ones
        for (int i = 0; i < NUM_CAND; i++) begin
            w[i] = 1'b1;
            for (int j = 0; j < i; j++)
                w[i] = w[i] & !le[j][i];
            for (int j = i + 1; j < NUM_CAND; j++)
                w[i] = w[i] & le[i][j];
        end
        win_o = '0;
        for (int i = 0; i < NUM_CAND; i++)
            if (w[i]) win_o = dec_t'(i);
        min_o = c[win_o];
    end

    a_r8_onehot_win: assert property (@(posedge clk) disable iff (rst) $onehot(w))
        else $error("R8: winner flags not one-hot");

    a_r8_min_bound: assert property (@(posedge clk) disable iff (rst)
        (min_o <= c[0]) && (min_o <= c[1]) && (min_o <= c[2]) && (min_o <= c[3]))
        else $error("R8: selected minimum exceeds a candidate");
endmodule

// File: rtl/acs_slice.sv
`timescale 1ns/1ps
module acs_slice
    import acs_pkg::*;
#(
    parameter int               STATE   = 0,
    parameter logic [TAB_W-1:0] SRC_TAB = src_tab_default(),
    parameter logic [TAB_W-1:0] BM_TAB  = bm_tab_default(),
    parameter acs_mode_e        MODE    = MODE_DIRECT,
    parameter metric_t          RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [VEC_W-1:0] met_i,
    input  logic [VEC_W-1:0] bm_i,
    output metric_t          met_o,
    output dec_t             dec_o
);
    logic [NUM_CAND*MW-1:0] cand;

    acs_cand_gen #(
        .STATE   (STATE),
        .SRC_TAB (SRC_TAB),
        .BM_TAB  (BM_TAB)
    ) u_cand (
        .met_i  (met_i),
        .bm_i   (bm_i),
        .cand_o (cand)
    );

    if (MODE == MODE_DIRECT) begin : g_direct
        metric_t min_val;
        dec_t    win;
        metric_t met_q;
        dec_t    dec_q;

        acs_min4 u_min (
            .clk    (clk),
            .rst    (rst),
            .cand_i (cand),
            .min_o  (min_val),
            .win_o  (win)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                met_q <= RST_VAL;
                dec_q <= '0;
            end else if (en) begin
                met_q <= min_val;
                dec_q <= win;
            end
        end

        assign met_o = met_q;
        assign dec_o = dec_q;

        a_r6_hold_direct: assert property (@(posedge clk) disable iff (rst)
            !en |=> ($stable(met_q) && $stable(dec_q)))
            else $error("R6: direct slice changed with enable low");
    end else begin : g_split
        metric_t c0, c1, c2, c3;
        half_t   lo, hi;
        logic    sel;
        half_t   lo_q, hi_q;
        logic    sel_q;
        dec_t    dec_q;

        always_comb begin
            c0 = metric_t'(cand[0*MW +: MW]);
            c1 = metric_t'(cand[1*MW +: MW]);
            c2 = metric_t'(cand[2*MW +: MW]);
            c3 = metric_t'(cand[3*MW +: MW]);
            lo = less_than(c1, c0) ? '{val: c1, pick: 1'b1} : '{val: c0, pick: 1'b0};
            hi = less_than(c3, c2) ? '{val: c3, pick: 1'b1} : '{val: c2, pick: 1'b0};
            sel = less_than(hi.val, lo.val);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q  <= '{val: RST_VAL, pick: 1'b0};
                hi_q  <= '{val: MET_MAX, pick: 1'b0};
                sel_q <= 1'b0;
                dec_q <= '0;
            end else if (en) begin
                lo_q  <= lo;
                hi_q  <= hi;
                sel_q <= sel;
                dec_q <= {sel, sel ? hi.pick : lo.pick};
            end
        end

        // deferred two-way choice, read directly by the recursion
        assign met_o = sel_q ? hi_q.val : lo_q.val;
        assign dec_o = dec_q;

        a_r7_split_hold: assert property (@(posedge clk) disable iff (rst)
            !en |=> ($stable(lo_q) && $stable(hi_q) && $stable(sel_q) && $stable(dec_q)))
            else $error("R7: split stage changed with enable low");
    end
endmodule

// File: rtl/acs_radix4.sv
`timescale 1ns/1ps
module acs_radix4
    import acs_pkg::*;
#(
    parameter acs_mode_e        MODE    = MODE_DIRECT,
    parameter logic [TAB_W-1:0] SRC_TAB = src_tab_default(),
    parameter logic [TAB_W-1:0] BM_TAB  = bm_tab_default()
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [VEC_W-1:0]       bm_i,
    output logic [VEC_W-1:0]       metric_o,
    output logic [NUM_ST*DEC_W-1:0] dec_o
);
    localparam logic [VEC_W-1:0] RST_VEC = reset_metrics();

    logic [VEC_W-1:0] met_fb;

    for (genvar s = 0; s < NUM_ST; s++) begin : g_state
        localparam metric_t RV = metric_t'(RST_VEC[s*MW +: MW]);
        metric_t m;
        dec_t    d;

        acs_slice #(
            .STATE   (s),
            .SRC_TAB (SRC_TAB),
            .BM_TAB  (BM_TAB),
            .MODE    (MODE),
            .RST_VAL (RV)
        ) u_slice (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .met_i (met_fb),
            .bm_i  (bm_i),
            .met_o (m),
            .dec_o (d)
        );

        assign met_fb[s*MW +: MW]       = m;
        assign dec_o[s*DEC_W +: DEC_W]  = d;
    end

    if (MODE == MODE_DIRECT) begin : g_out_direct
        assign metric_o = met_fb;
    end else begin : g_out_split
        logic             en_q;
        logic [VEC_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q  <= 1'b0;
                out_q <= RST_VEC;
            end else begin
                en_q <= en;
                if (en_q) out_q <= met_fb;
            end
        end

        assign metric_o = out_q;
    end

    a_r1_reset_vals: assert property (@(posedge clk)
        rst |=> (metric_o == RST_VEC) && (dec_o == '0))
        else $error("R1: outputs not at reset values after reset");
endmodule

// File: tb/acs_radix4_bench.sv
`timescale 1ns/1ps
module acs_radix4_bench;
    import acs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [VEC_W-1:0] bm = '0;
    logic [VEC_W-1:0] met_d, met_s;
    logic [NUM_ST*DEC_W-1:0] dec_d, dec_s;

    always #10 clk = ~clk;

    acs_radix4 #(.MODE(MODE_DIRECT)) u_acs_radix4 (
        .clk(clk), .rst(rst), .en(en), .bm_i(bm), .metric_o(met_d), .dec_o(dec_d));

    acs_radix4 #(.MODE(MODE_SPLIT)) u_acs_radix4_split (
        .clk(clk), .rst(rst), .en(en), .bm_i(bm), .metric_o(met_s), .dec_o(dec_s));

    typedef struct {
        logic [VEC_W-1:0]        met;
        logic [NUM_ST*DEC_W-1:0] dec;
        logic [VEC_W-1:0]        lag;
        string                   tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int mdl  [NUM_ST];
    int lagm [NUM_ST];
    int mdec [NUM_ST];
    bit en_prev = 0;
    int bv   [NUM_ST];

    function automatic int clampv(int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    task automatic step(bit r, bit e, string tag);
        exp_t it;
        int nm [NUM_ST];
        @(negedge clk);
        rst = r;
        en  = e;
        for (int i = 0; i < NUM_ST; i++) bm[i*MW +: MW] = MW'(bv[i]);
        if (r) begin
            for (int s = 0; s < NUM_ST; s++) begin
                mdl[s]  = (s == 0) ? 0 : 8191;
                lagm[s] = mdl[s];
                mdec[s] = 0;
            end
            en_prev = 0;
        end else begin
            if (en_prev) for (int s = 0; s < NUM_ST; s++) lagm[s] = mdl[s];
            if (e) begin
                for (int s = 0; s < NUM_ST; s++) begin
                    int best = 0;
                    int idx  = 0;
                    for (int c = 0; c < NUM_CAND; c++) begin
                        int v = clampv(mdl[(4*s + c) % 8] + bv[(s + 3*c) % 8]);
                        if (c == 0 || v < best) begin best = v; idx = c; end
                    end
                    nm[s]   = best;
                    mdec[s] = idx;
                end
                for (int s = 0; s < NUM_ST; s++) mdl[s] = nm[s];
            end
            en_prev = e;
        end
        for (int s = 0; s < NUM_ST; s++) begin
            it.met[s*MW +: MW]       = MW'(mdl[s]);
            it.lag[s*MW +: MW]       = MW'(lagm[s]);
            it.dec[s*DEC_W +: DEC_W] = DEC_W'(mdec[s]);
        end
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic chk(string tag, string what, logic [VEC_W-1:0] got, logic [VEC_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // monitor: pops one expected item per clock, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                chk(it.tag, "direct metrics", met_d, it.met);
                chk(it.tag, "direct decisions", VEC_W'(dec_d), VEC_W'(it.dec));
                chk("R7", "split decisions", VEC_W'(dec_s), VEC_W'(it.dec));
                chk("R7", "split metrics", met_s, it.lag);
            end
        end
    end

    task automatic fill(int lo, int span);
        for (int i = 0; i < NUM_ST; i++) bv[i] = int'($urandom_range(span)) + lo;
    endtask

    task automatic fill_const(int v);
        for (int i = 0; i < NUM_ST; i++) bv[i] = v;
    endtask

    initial begin
        fill_const(0);
        repeat (3) step(1, 0, "R1");
        // all-zero branches from reset: equal candidates, lowest index wins
        repeat (4) step(0, 1, "R4/R8");
        repeat (40) begin fill(-1000, 2000); step(0, 1, "R2"); end
        repeat (6)  begin fill(-8192, 16383); step(0, 0, "R6"); end
        fill_const(8191);
        repeat (6) step(0, 1, "R3");
        fill_const(-8192);
        repeat (6) step(0, 1, "R3");
        repeat (30) begin fill(-8192, 16383); step(0, 1, "R5"); end
        repeat (40) begin fill(-3000, 6000); step(0, ($urandom_range(1) == 1), "R7"); end
        fill_const(5);
        step(1, 1, "R1");
        repeat (10) begin fill(-500, 1000); step(0, 1, "R2"); end
        fill_const(0);
        repeat (3) step(0, 0, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule